// File: doc/BRIEF.md
# Context-Pointer Register Bank Mapper

This block gives a CPU sixteen 16-bit general-purpose registers that have no flip-flops of their own. Each register is a word in on-chip RAM. A context pointer holds the byte address of register 0 of the active bank, and register n sits at that pointer plus 2*n. A single pointer write changes the active bank, and any number of banks can be placed in the RAM. Two banks may overlap, so the upper registers of one bank can be the lower registers of the next, which lets a caller pass arguments to a callee without copying.

A register request carries up to two reads (ports A and B) and one write. The request is accepted when the block is not busy. Its operations then go onto the single RAM port, one per cycle, in a fixed order. The RAM is synchronous and returns read data one cycle after the address is presented. The results come back together with a one-cycle valid pulse. Any access that would fall beyond the end of the RAM is dropped, and the block raises an error pulse.

Top module: `gpr_bank_mapper`

## Requirements
- R1: While reset is asserted and after its release: cp_o is 0, and busy_o, ram_en_o, rd_valid_o and range_err_o are low.
- R2: A pointer write with cp_we_i stores cp_wdata_i with bit 0 cleared. The value appears on cp_o in the next cycle, and RAM accesses issued from that cycle onward use it. Without cp_we_i, cp_o holds its value.
- R3: The RAM byte address of register n is cp_o + 2*n.
- R4: A request is accepted on a clock edge where req_valid_i is high and busy_o is low. From the next cycle its enabled operations are issued one per cycle in this order: read A, read B, write. Disabled operations are skipped. A write drives ram_we_o high and puts wr_data_i on ram_wdata_o.
- R5: Read data is captured one cycle after its RAM access. rd_a_data_o and rd_b_data_o are cleared on acceptance. A disabled read port stays 0.
- R6: Within one request, reads see register contents from before that request's write.
- R7: An access whose address is at or above the RAM size (1024 bytes) does not drive ram_en_o. It pulses range_err_o for one cycle in the following cycle, and its read result is 0.
- R8: Banks overlap freely. A register written through one pointer value reads back through any other pointer value that maps to the same byte address.
- R9: busy_o is high from the cycle after acceptance until the last operation has been issued and the last read has been captured. No RAM access happens while busy_o is low.
- R10: rd_valid_o pulses for exactly one cycle, two cycles after the last read of a request is issued. Requests without reads produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_we_i | input | 1 | Context pointer write strobe |
| cp_wdata_i | input | 10 | New context pointer (bit 0 ignored) |
| cp_o | output | 10 | Current context pointer |
| req_valid_i | input | 1 | Register request present |
| rd_a_en_i | input | 1 | Read port A enable |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_b_en_i | input | 1 | Read port B enable |
| rd_b_idx_i | input | 4 | Read port B register index |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | 16 | Write data |
| busy_o | output | 1 | Request in progress, new requests held off |
| rd_valid_o | output | 1 | Read results valid (one-cycle pulse) |
| rd_a_data_o | output | 16 | Read port A result |
| rd_b_data_o | output | 16 | Read port B result |
| range_err_o | output | 1 | Out-of-range access pulse |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 10 | RAM byte address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, one cycle after the address |

## Verification
The bench targets a read and a write of the same register in one request. A design that issued the write first would return the new value instead of the old one. It also moves the pointer so that one bank's upper registers become another bank's lower registers; a mapper that scaled the index wrongly or kept bit 0 of the pointer would read the wrong word. Pointers near the top of the RAM split a request into legal and illegal accesses. A design that wrapped the address would overwrite low RAM, and one that left the captured data in place would return stale data where it must return zero. Pointer writes that land while a request is in flight check that operations issued later use the new base, and back-to-back requests catch a valid pulse that is late, missing or two cycles long.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;
  typedef enum logic [1:0] {
    OP_RD_A = 2'd0,
    OP_RD_B = 2'd1,
    OP_WR   = 2'd2
  } gpr_op_e;
endpackage

// File: rtl/gpr_cp_reg.sv
module gpr_cp_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] cp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cp_o <= '0;
    else if (we_i) cp_o <= {wdata_i[ADDR_W-1:1], 1'b0};
  end
endmodule

// File: rtl/gpr_addr_calc.sv
module gpr_addr_calc #(
  parameter int ADDR_W    = 10,
  parameter int IDX_W     = 4,
  parameter int RAM_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] cp_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_range_o
);
  // one spare bit so the carry past the RAM top stays visible
  localparam int SUM_W = ((ADDR_W > IDX_W + 1) ? ADDR_W : IDX_W + 1) + 1;

  logic [SUM_W-1:0] sum;

  assign sum        = SUM_W'(cp_i) + SUM_W'({idx_i, 1'b0});
  assign in_range_o = sum < SUM_W'(RAM_BYTES);
  assign addr_o     = sum[ADDR_W-1:0];
endmodule

// File: rtl/gpr_access_seq.sv
module gpr_access_seq
  import gpr_bank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              rd_a_en_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic              rd_b_en_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [IDX_W-1:0]  cur_idx_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              in_range_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic              range_err_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic [2:0]        pend_q;  // {wr, rd_b, rd_a}
  logic [IDX_W-1:0]  rda_idx_q, rdb_idx_q, wr_idx_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cap_q, cap_port_q, cap_zero_q, cap_last_q;
  logic              rd_valid_q, err_q;
  logic [DATA_W-1:0] rd_q [2];

  gpr_op_e cur_op;
  logic    cur_valid, is_rd, more_rd, accept;

  assign busy_o = (|pend_q) | cap_q;
  assign accept = req_valid_i & ~busy_o;

  always_comb begin
    cur_op    = OP_WR;
    cur_idx_o = wr_idx_q;
    if (pend_q[0]) begin
      cur_op    = OP_RD_A;
      cur_idx_o = rda_idx_q;
    end else if (pend_q[1]) begin
      cur_op    = OP_RD_B;
      cur_idx_o = rdb_idx_q;
    end
  end

  assign cur_valid = |pend_q;
  assign is_rd     = cur_op != OP_WR;
  assign more_rd   = (cur_op == OP_RD_A) & pend_q[1];

  assign ram_en_o    = cur_valid & in_range_i;
  assign ram_we_o    = ram_en_o & ~is_rd;
  assign ram_addr_o  = addr_i;
  assign ram_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      rda_idx_q <= '0;
      rdb_idx_q <= '0;
      wr_idx_q  <= '0;
      wdata_q   <= '0;
    end else if (accept) begin
      pend_q    <= {wr_en_i, rd_b_en_i, rd_a_en_i};
      rda_idx_q <= rd_a_idx_i;
      rdb_idx_q <= rd_b_idx_i;
      wr_idx_q  <= wr_idx_i;
      wdata_q   <= wr_data_i;
    end else if (cur_valid) begin
      pend_q <= pend_q & ~(3'b001 << cur_op);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q      <= 1'b0;
      cap_port_q <= 1'b0;
      cap_zero_q <= 1'b0;
      cap_last_q <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      cap_q      <= cur_valid & is_rd;
      cap_port_q <= cur_op == OP_RD_B;
      cap_zero_q <= ~in_range_i;
      cap_last_q <= ~more_rd;
      err_q      <= cur_valid & ~in_range_i;
      rd_valid_q <= cap_q & cap_last_q;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          rd_q[p] <= '0;
      else if (accept)                      rd_q[p] <= '0;
      else if (cap_q && cap_port_q == 1'(p)) rd_q[p] <= cap_zero_q ? '0 : ram_rdata_i;
    end
  end

  assign rd_a_data_o = rd_q[0];
  assign rd_b_data_o = rd_q[1];
  assign rd_valid_o  = rd_valid_q;
  assign range_err_o = err_q;
endmodule

// File: rtl/gpr_bank_mapper.sv
module gpr_bank_mapper #(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 16,
  parameter int RAM_BYTES = 1024,
  localparam int ADDR_W   = $clog2(RAM_BYTES),
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cp_we_i,
  input  logic [ADDR_W-1:0] cp_wdata_i,
  output logic [ADDR_W-1:0] cp_o,
  input  logic              req_valid_i,
  input  logic              rd_a_en_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic              rd_b_en_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic              range_err_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_in_range;

  gpr_cp_reg #(.ADDR_W(ADDR_W)) u_cp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cp_we_i),
    .wdata_i (cp_wdata_i),
    .cp_o    (cp_o)
  );

  gpr_addr_calc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RAM_BYTES(RAM_BYTES)) u_addr (
    .cp_i       (cp_o),
    .idx_i      (cur_idx),
    .addr_o     (cur_addr),
    .in_range_o (cur_in_range)
  );

  gpr_access_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .rd_a_en_i   (rd_a_en_i),
    .rd_a_idx_i  (rd_a_idx_i),
    .rd_b_en_i   (rd_b_en_i),
    .rd_b_idx_i  (rd_b_idx_i),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .cur_idx_o   (cur_idx),
    .addr_i      (cur_addr),
    .in_range_i  (cur_in_range),
    .busy_o      (busy_o),
    .rd_valid_o  (rd_valid_o),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_data_o (rd_b_data_o),
    .range_err_o (range_err_o),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i)
  );
endmodule

// File: rtl/gpr_bank_mapper_chk.sv
module gpr_bank_mapper_chk #(
  parameter int NUM_REGS  = 16,
  parameter int RAM_BYTES = 1024,
  parameter int ADDR_W    = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cp_we_i,
  input logic [ADDR_W-1:0] cp_wdata_i,
  input logic [ADDR_W-1:0] cp_o,
  input logic              req_valid_i,
  input logic              rd_a_en_i,
  input logic              rd_b_en_i,
  input logic              wr_en_i,
  input logic              busy_o,
  input logic              rd_valid_o,
  input logic              range_err_o,
  input logic              ram_en_o,
  input logic [ADDR_W-1:0] ram_addr_o
);
  a_r2_cp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_we_i |=> cp_o == {$past(cp_wdata_i[ADDR_W-1:1]), 1'b0});

  a_r2_cp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_we_i |=> $stable(cp_o));

  a_r3_addr_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> (!ram_addr_o[0] && int'(ram_addr_o) >= int'(cp_o)
                  && int'(ram_addr_o) <= int'(cp_o) + 2 * (NUM_REGS - 1)));

  a_r4_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && (rd_a_en_i || rd_b_en_i || wr_en_i)) |=> busy_o);

  a_r7_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> int'(ram_addr_o) < RAM_BYTES);

  a_r7_err_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> $past(busy_o && !ram_en_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_en_o);

  a_r10_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind gpr_bank_mapper gpr_bank_mapper_chk #(
  .NUM_REGS (NUM_REGS),
  .RAM_BYTES(RAM_BYTES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cp_we_i     (cp_we_i),
  .cp_wdata_i  (cp_wdata_i),
  .cp_o        (cp_o),
  .req_valid_i (req_valid_i),
  .rd_a_en_i   (rd_a_en_i),
  .rd_b_en_i   (rd_b_en_i),
  .wr_en_i     (wr_en_i),
  .busy_o      (busy_o),
  .rd_valid_o  (rd_valid_o),
  .range_err_o (range_err_o),
  .ram_en_o    (ram_en_o),
  .ram_addr_o  (ram_addr_o)
);

// File: tb/tb_gpr_bank_mapper.sv
`timescale 1ns/1ps
module tb_gpr_bank_mapper;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cp_we = 1'b0; logic [9:0] cp_wdata = '0; logic [9:0] cp;
  logic req_valid = 1'b0, a_en = 1'b0, b_en = 1'b0, w_en = 1'b0;
  logic [3:0] a_idx = '0, b_idx = '0, w_idx = '0;
  logic [15:0] w_data = '0;
  logic busy, rd_valid, range_err, ram_en, ram_we;
  logic [15:0] rd_a, rd_b, ram_wdata, ram_rdata;
  logic [9:0] ram_addr;

  int n_cmp = 0, n_bad = 0, err_seen = 0;

  always #5 clk = ~clk;

  gpr_bank_mapper dut (
    .clk_i(clk), .rst_ni(rst_ni), .cp_we_i(cp_we), .cp_wdata_i(cp_wdata), .cp_o(cp),
    .req_valid_i(req_valid), .rd_a_en_i(a_en), .rd_a_idx_i(a_idx), .rd_b_en_i(b_en),
    .rd_b_idx_i(b_idx), .wr_en_i(w_en), .wr_idx_i(w_idx), .wr_data_i(w_data),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_a_data_o(rd_a), .rd_b_data_o(rd_b),
    .range_err_o(range_err), .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  // RAM serving the design
  logic [15:0] tb_mem [512];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) tb_mem[ram_addr[9:1]] <= ram_wdata;
      else        ram_rdata <= tb_mem[ram_addr[9:1]];
    end
  end

  // behavioural reference
  logic [15:0] ref_mem [512];
  int q_kind[$];
  int q_idx[$];
  logic [15:0] m_wdata, m_cap_val;
  logic [15:0] m_rd [2];
  logic [9:0] m_cp;
  bit m_cap, m_cap_last, m_rdv, m_err, m_busy_now, m_inr;
  int m_cap_port, m_a, m_k, m_i;

  function automatic bit m_busy();
    return (q_kind.size() > 0) || m_cap;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_kind.delete(); q_idx.delete();
      m_cp = '0; m_cap = 0; m_rdv = 0; m_err = 0; m_rd[0] = '0; m_rd[1] = '0; m_wdata = '0;
    end else begin
      m_busy_now = m_busy();
      m_rdv = 0; m_err = 0;
      if (m_cap) begin
        m_rd[m_cap_port] = m_cap_val; m_rdv = m_cap_last; m_cap = 0;
      end
      if (q_kind.size() > 0) begin
        m_a = int'(m_cp) + 2 * q_idx[0];
        m_k = q_kind.pop_front(); m_i = q_idx.pop_front();
        m_inr = m_a < 1024;
        m_err = !m_inr;
        if (m_k < 2) begin
          m_cap = 1; m_cap_port = m_k;
          m_cap_val = m_inr ? ref_mem[m_a / 2] : 16'h0;
          m_cap_last = 1;
          foreach (q_kind[j]) if (q_kind[j] < 2) m_cap_last = 0;
        end else if (m_inr) ref_mem[m_a / 2] = m_wdata;
      end
      if (req_valid && !m_busy_now) begin
        if (a_en) begin q_kind.push_back(0); q_idx.push_back(int'(a_idx)); end
        if (b_en) begin q_kind.push_back(1); q_idx.push_back(int'(b_idx)); end
        if (w_en) begin q_kind.push_back(2); q_idx.push_back(int'(w_idx)); end
        m_wdata = w_data; m_rd[0] = '0; m_rd[1] = '0;
      end
      if (cp_we) m_cp = {cp_wdata[9:1], 1'b0};
    end
  end

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_ni) begin
      bit e_en; int e_a;
      e_en = 0; e_a = 0;
      if (q_kind.size() > 0) begin
        e_a = int'(m_cp) + 2 * q_idx[0];
        e_en = e_a < 1024;
      end
      cmp("R2", "cp_o", 32'(cp), 32'(m_cp));
      cmp("R9", "busy_o", 32'(busy), 32'(m_busy()));
      cmp("R4", "ram_en_o", 32'(ram_en), 32'(e_en));
      if (e_en) begin
        cmp("R4", "ram_we_o", 32'(ram_we), 32'(q_kind[0] == 2));
        cmp("R3", "ram_addr_o", 32'(ram_addr), 32'(e_a));
        if (q_kind[0] == 2) cmp("R4", "ram_wdata_o", 32'(ram_wdata), 32'(m_wdata));
      end
      cmp("R7", "range_err_o", 32'(range_err), 32'(m_err));
      cmp("R10", "rd_valid_o", 32'(rd_valid), 32'(m_rdv));
      cmp("R5", "rd_a_data_o", 32'(rd_a), 32'(m_rd[0]));
      cmp("R5", "rd_b_data_o", 32'(rd_b), 32'(m_rd[1]));
      if (range_err) err_seen++;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic set_cp(logic [9:0] v);
    cp_wdata = v; cp_we = 1'b1;
    @(negedge clk);
    cp_we = 1'b0;
  endtask

  task automatic send(bit ae, int ai, bit be, int bi, bit we, int wi, logic [15:0] wd,
                      bit cw, logic [9:0] cv);
    while (busy) @(negedge clk);
    a_en = ae; a_idx = 4'(ai); b_en = be; b_idx = 4'(bi);
    w_en = we; w_idx = 4'(wi); w_data = wd; req_valid = 1'b1;
    cp_we = cw; cp_wdata = cv;
    @(negedge clk);
    req_valid = 1'b0; a_en = 0; b_en = 0; w_en = 0; cp_we = 1'b0;
  endtask

  // waits for the first idle cycle, which is the valid cycle for reads
  task automatic wait_done();
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      tb_mem[i]  = 16'(i * 16'h0107) ^ 16'hA5C3;
      ref_mem[i] = 16'(i * 16'h0107) ^ 16'hA5C3;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "reset cp_o", 32'(cp), 32'h0);
    cmp("R1", "reset busy_o", 32'(busy), 32'h0);
    cmp("R1", "reset ram_en_o", 32'(ram_en), 32'h0);
    cmp("R1", "reset rd_valid_o", 32'(rd_valid), 32'h0);
    cmp("R1", "reset range_err_o", 32'(range_err), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 odd pointer is aligned
    set_cp(10'h041);
    cmp("R2", "aligned cp_o", 32'(cp), 32'h040);

    // R6 read sees value from before the same request's write
    send(0, 0, 0, 0, 1, 3, 16'h1234, 0, 0);
    wait_done();
    send(1, 3, 0, 0, 1, 3, 16'hBEEF, 0, 0);
    @(negedge clk); wait_done();
    cmp("R6", "old value read", 32'(rd_a), 32'h1234);
    send(1, 3, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); wait_done();
    cmp("R6", "new value read", 32'(rd_a), 32'hBEEF);
    cmp("R5", "disabled port b zero", 32'(rd_b), 32'h0);
    cmp("R10", "valid with reads", 32'(rd_valid), 32'h1);

    // R8 overlapping banks: R8 at base 0x100 is R4 at base 0x108
    set_cp(10'h100);
    send(0, 0, 0, 0, 1, 8, 16'h5A5A, 0, 0);
    wait_done();
    set_cp(10'h108);
    send(1, 4, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); wait_done();
    cmp("R8", "alias read", 32'(rd_a), 32'h5A5A);

    // R7 top of RAM: R15 at 1008+30 is out, R7 at 1022 is in
    set_cp(10'd1008);
    begin
      int e0;
      e0 = err_seen;
      send(1, 15, 1, 7, 0, 0, 0, 0, 0);
      @(negedge clk); wait_done();
      cmp("R7", "out-of-range read zero", 32'(rd_a), 32'h0);
      cmp("R7", "one error pulse", 32'(err_seen - e0), 32'd1);
      cmp("R10", "valid after mixed reads", 32'(rd_valid), 32'h1);
    end

    // R10 write-only request gives no valid pulse
    set_cp(10'h0);
    send(0, 0, 0, 0, 1, 1, 16'h0F0F, 0, 0);
    @(negedge clk);
    @(negedge clk);
    cmp("R10", "no valid for write-only", 32'(rd_valid), 32'h0);

    // random traffic, pointer moves also while busy
    for (int n = 0; n < 600; n++) begin
      bit cw;
      logic [9:0] cv;
      cw = ($urandom_range(0, 3) == 0);
      cv = ($urandom_range(0, 1) == 0) ? 10'($urandom_range(0, 1023))
                                       : 10'($urandom_range(960, 1023));
      send(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           16'($urandom), cw, cv);
      if ($urandom_range(0, 2) == 0) begin
        @(negedge clk);
        if ($urandom_range(0, 1) == 0) set_cp(10'($urandom_range(0, 1023)));
      end
    end
    wait_done();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule